// File: doc/BRIEF.md
# NAND Read Timing Calculator

This block converts nanosecond timing targets for a NAND flash read interface into cycle counts that can be loaded into timing registers. A one-cycle `start` pulse captures the clock period, the setup and hold targets, the number of attached flash devices, three optional device read timings, the board propagation delay range and a requested sample delay. The block then runs a multi-cycle sequence and raises `done`. The results are the data setup, data hold and address setup cycle counts, a half-period reference flag and a fine sample-delay factor.

The cycle counts come from ceiling divisions. These run on one shared iterative divider. When all three device timings are known, the block computes the width of the read data eye. It places the sample point at the eye's centre by trading added setup cycles against the quantized fine delay, until the quantized sample lands inside the eye. When any device timing is unknown, a simpler loop moves excess requested delay into setup cycles. Every loop is bounded, both by the setup-cycle maximum and by an iteration cap.

Top module: `nrt_calc`

## Requirements
- R1: After reset `busy` and `done` are 0, and every result output (`setup_cyc`, `hold_cyc`, `addr_cyc`, `half_period`, `sample_factor`, `saturated`) is 0.
- R2: When `chip_count` is exactly 2, each of the three setup/hold targets is raised by 5 ns. When `chip_count` is 3 or more, each is raised by 10 ns. With 0 or 1 devices the targets are unchanged.
- R3: Each target is converted with ceiling(target / period). Data setup and data hold get at least 1 cycle, and address setup may be 0. Data hold and address setup saturate at 255. Data setup saturates at the setup maximum.
- R4: `half_period` is 1 exactly when the period exceeds 16 ns. The delay shift is then 4; otherwise it is 3.
- R5: The maximum fine delay is 0 when the period exceeds 32 ns. Otherwise it is min((15 × period) >> shift, 16) ns.
- R6: If any device timing is negative (two's complement), the ideal delay starts at `sample_req_ns`. While it exceeds the maximum fine delay and setup is below its maximum, one setup cycle is added and one period is subtracted from the delay, which is floored at 0.
- R7: With all device timings known, eye = prop_min + high_hold + period × setup − prop_max − access. While eye ≤ 0 and setup is below its maximum, one setup cycle is added and the eye grows by one period.
- R8: The ideal delay is (prop_max + access + prop_min + high_hold − period × setup) >>> 1, floored at 0. While it exceeds the maximum fine delay and setup is below its maximum, one setup cycle is added and half a period is subtracted from the delay, floored at 0.
- R9: `sample_factor` = ceiling((ideal << shift) / period), saturated at 15. On the unknown-timing path this is the final factor.
- R10: On the known-timing path, with quantized = (factor × period) >> shift, the block loops while |quantized − ideal| > eye >>> 1 and setup is below its maximum. If quantized > ideal, a nonzero factor is decremented. Otherwise one setup cycle is added, the eye grows by one period, 1.5 periods are subtracted from the ideal delay (floored at 0), and the factor is recomputed.
- R11: `setup_cyc` never exceeds the setup maximum (parameter `DS_MAX`). Every loop that would add a setup cycle stops at that maximum.
- R12: When a loop still needs to iterate after `LOOP_CAP` iterations, the block stops, sets `saturated`, and reports its current values. A factor that has not yet been computed reads 0.
- R13: Inputs are captured only by `start` while the block is idle. A `start` while `busy` is ignored. All outputs, `done` included, hold their values while idle until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Capture inputs and begin a calculation |
| period_ns | input | PW | Interface clock period in ns (nonzero) |
| tgt_setup_ns | input | TW | Target data setup time |
| tgt_hold_ns | input | TW | Target data hold time |
| tgt_addr_ns | input | TW | Target address setup time |
| chip_count | input | CW | Number of attached flash devices |
| dev_access_ns | input | TW (signed) | Device read access time, negative if unknown |
| dev_low_hold_ns | input | TW (signed) | Device output hold after strobe low, negative if unknown |
| dev_high_hold_ns | input | TW (signed) | Device output hold after strobe high, negative if unknown |
| prop_min_ns | input | TW | Minimum board propagation delay |
| prop_max_ns | input | TW | Maximum board propagation delay |
| sample_req_ns | input | TW | Requested sample delay for the unknown-timing path |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | Results valid |
| setup_cyc | output | DS_W | Data setup cycle count |
| hold_cyc | output | DS_W | Data hold cycle count |
| addr_cyc | output | DS_W | Address setup cycle count |
| half_period | output | 1 | Fine delay referenced to half periods |
| sample_factor | output | F_W | Fine sample delay factor |
| saturated | output | 1 | A loop hit its iteration cap |

## Verification
The bench builds the block with `DS_MAX` = 12 and `LOOP_CAP` = 8 instead of 255 and 512. At these values the setup ceiling and the iteration cap can each be reached in a few cases with periods of 5 to 40 ns. One case stops at the setup limit with a saturated factor, and another runs out of iterations in the unknown-timing loop. The remaining cases cover the period boundaries at 16/17 and 32/33 ns, the three device-count margins, eye opening, delay centring, and one refinement pass that first decrements the factor and then adds a setup cycle.

// File: rtl/nrt_pkg.sv
package nrt_pkg;
   localparam int NRT_SW = 16;
   typedef logic signed [NRT_SW-1:0] sns_t;

   typedef enum logic [3:0] {
      S_IDLE, S_DS, S_DH, S_AS, S_PATH, S_SIMPLE,
      S_EYE, S_IDEAL0, S_CENTER, S_FACT, S_REFINE
   } nrt_state_e;
endpackage

// File: rtl/nrt_div.sv
module nrt_div #(
   parameter int NUM_W = 21,
   parameter int DEN_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [NUM_W-1:0] num,
   input  logic [DEN_W-1:0] den,
   output logic [NUM_W-1:0] quo,
   output logic             vld
);
   localparam int CNT_W = $clog2(NUM_W + 1);

   logic [DEN_W-1:0] rem, den_l;
   logic [CNT_W-1:0] cnt;
   logic             run;
   logic [DEN_W:0]   shifted;
   logic             ge;

   always_comb begin
      shifted = {rem, quo[NUM_W-1]};
      ge      = shifted >= {1'b0, den_l};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem   <= '0;
         den_l <= '0;
         quo   <= '0;
         cnt   <= '0;
         run   <= 1'b0;
         vld   <= 1'b0;
      end else begin
         vld <= 1'b0;
         if (start && !run) begin
            quo   <= num;
            den_l <= den;
            rem   <= '0;
            cnt   <= CNT_W'(NUM_W);
            run   <= 1'b1;
         end else if (run) begin
            rem <= ge ? (shifted[DEN_W-1:0] - den_l) : shifted[DEN_W-1:0];
            quo <= {quo[NUM_W-2:0], ge};
            cnt <= cnt - 1'b1;
            if (cnt == CNT_W'(1)) begin
               run <= 1'b0;
               vld <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/nrt_window.sv
module nrt_window
   import nrt_pkg::*;
#(
   parameter int PW        = 8,
   parameter int MAXF      = 15,
   parameter int DLL_LIMIT = 32,
   parameter int DLY_CAP   = 16
) (
   input  logic [PW-1:0] per,
   output logic          half,
   output logic [2:0]    shift,
   output sns_t          maxd
);
   logic [NRT_SW-1:0] prod, scaled;

   always_comb begin
      half   = per > PW'(DLL_LIMIT / 2);
      shift  = half ? 3'd4 : 3'd3;
      prod   = NRT_SW'(MAXF) * NRT_SW'(per);
      scaled = prod >> shift;
      if (per > PW'(DLL_LIMIT))
         maxd = '0;
      else if (scaled > NRT_SW'(DLY_CAP))
         maxd = sns_t'(DLY_CAP);
      else
         maxd = sns_t'(scaled);
   end
endmodule

// File: rtl/nrt_quant.sv
module nrt_quant
   import nrt_pkg::*;
#(
   parameter int PW  = 8,
   parameter int F_W = 4
) (
   input  logic [F_W-1:0] factor,
   input  logic [PW-1:0]  per,
   input  logic [2:0]     shift,
   output sns_t           qdly
);
   logic [NRT_SW-1:0] prod;

   always_comb begin
      prod = NRT_SW'(factor) * NRT_SW'(per);
      qdly = sns_t'(prod >> shift);
   end
endmodule

// File: rtl/nrt_calc.sv
module nrt_calc
   import nrt_pkg::*;
#(
   parameter int PW          = 8,
   parameter int TW          = 8,
   parameter int CW          = 4,
   parameter int DS_W        = 8,
   parameter int DS_MAX      = 255,
   parameter int MAXF        = 15,
   parameter int LOOP_CAP    = 512,
   parameter int MARGIN_TWO  = 5,
   parameter int MARGIN_MANY = 10,
   parameter int DLL_LIMIT   = 32,
   parameter int DLY_CAP     = 16,
   localparam int F_W        = $clog2(MAXF + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [PW-1:0]        period_ns,
   input  logic [TW-1:0]        tgt_setup_ns,
   input  logic [TW-1:0]        tgt_hold_ns,
   input  logic [TW-1:0]        tgt_addr_ns,
   input  logic [CW-1:0]        chip_count,
   input  logic signed [TW-1:0] dev_access_ns,
   input  logic signed [TW-1:0] dev_low_hold_ns,
   input  logic signed [TW-1:0] dev_high_hold_ns,
   input  logic [TW-1:0]        prop_min_ns,
   input  logic [TW-1:0]        prop_max_ns,
   input  logic [TW-1:0]        sample_req_ns,
   output logic                 busy,
   output logic                 done,
   output logic [DS_W-1:0]      setup_cyc,
   output logic [DS_W-1:0]      hold_cyc,
   output logic [DS_W-1:0]      addr_cyc,
   output logic                 half_period,
   output logic [F_W-1:0]       sample_factor,
   output logic                 saturated
);
   localparam int NUM_W = NRT_SW + 5;
   localparam int IT_W  = $clog2(LOOP_CAP + 1);
   localparam logic [NUM_W-1:0] DSMAX_N = NUM_W'(DS_MAX);
   localparam logic [NUM_W-1:0] ALL_N   = NUM_W'((1 << DS_W) - 1);
   localparam logic [NUM_W-1:0] MAXF_N  = NUM_W'(MAXF);
   localparam logic [DS_W-1:0]  DSMAX_D = DS_W'(DS_MAX);
   localparam logic [IT_W-1:0]  CAP_I   = IT_W'(LOOP_CAP);

   if (DS_MAX < 1 || DS_MAX > (1 << DS_W) - 1) begin : g_bad_dsmax
      $error("nrt_calc: DS_MAX outside the setup counter range");
   end
   if (NRT_SW < 2 * PW || TW >= NRT_SW) begin : g_bad_width
      $error("nrt_calc: signed working width too narrow for inputs");
   end
   if (LOOP_CAP < 1) begin : g_bad_cap
      $error("nrt_calc: LOOP_CAP must be positive");
   end

   nrt_state_e st;
   logic [PW-1:0] per_l;
   sns_t tds_l, tdh_l, tas_l, rea_l, rloh_l, rhoh_l, pmin_l, pmax_l, sreq_l;
   sns_t ideal, eye, setup_ns, margin_s;
   logic [IT_W-1:0] iter;
   logic div_issued, simple_l;

   // shared divider
   logic             div_start, div_vld;
   logic [NUM_W-1:0] div_num, div_q;
   nrt_div #(.NUM_W(NUM_W), .DEN_W(PW)) u_div (
      .clk(clk), .rst_n(rst_n), .start(div_start), .num(div_num),
      .den(per_l), .quo(div_q), .vld(div_vld));

   logic       win_half;
   logic [2:0] win_shift;
   sns_t       maxd;
   nrt_window #(.PW(PW), .MAXF(MAXF), .DLL_LIMIT(DLL_LIMIT), .DLY_CAP(DLY_CAP)) u_win (
      .per(per_l), .half(win_half), .shift(win_shift), .maxd(maxd));

   sns_t qdly;
   nrt_quant #(.PW(PW), .F_W(F_W)) u_quant (
      .factor(sample_factor), .per(per_l), .shift(win_shift), .qdly(qdly));

   sns_t per_s, half_per_s, ds_s, err, diff, ideal_dec, ideal_ref, ideal_sim, eye_ctr;
   logic any_unknown, need_more, ref_cond;

   always_comb begin
      margin_s = '0;
      if (chip_count > CW'(2))       margin_s = sns_t'(MARGIN_MANY);
      else if (chip_count == CW'(2)) margin_s = sns_t'(MARGIN_TWO);
      per_s       = sns_t'(per_l);
      half_per_s  = per_s >>> 1;
      ds_s        = sns_t'(setup_cyc);
      any_unknown = (rea_l < 0) || (rloh_l < 0) || (rhoh_l < 0);
      need_more   = setup_cyc < DSMAX_D;
      diff        = qdly - ideal;
      err         = (diff < 0) ? -diff : diff;
      ref_cond    = (err > (eye >>> 1)) && need_more;
      ideal_sim   = ideal - per_s;
      ideal_dec   = ideal - half_per_s;
      ideal_ref   = ideal - half_per_s - per_s;
      eye_ctr     = (pmax_l + rea_l + pmin_l + rhoh_l - setup_ns) >>> 1;
      div_num     = '0;
      case (st)
         S_DS:    div_num = NUM_W'($unsigned(tds_l)) + NUM_W'(per_l) - 1'b1;
         S_DH:    div_num = NUM_W'($unsigned(tdh_l)) + NUM_W'(per_l) - 1'b1;
         S_AS:    div_num = NUM_W'($unsigned(tas_l)) + NUM_W'(per_l) - 1'b1;
         S_FACT:  div_num = (NUM_W'($unsigned(ideal)) << win_shift) + NUM_W'(per_l) - 1'b1;
         default: div_num = '0;
      endcase
      div_start = (st == S_DS || st == S_DH || st == S_AS || st == S_FACT) && !div_issued;
      busy      = st != S_IDLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= S_IDLE;
         {per_l, tds_l, tdh_l, tas_l, rea_l, rloh_l, rhoh_l} <= '0;
         {pmin_l, pmax_l, sreq_l, ideal, eye, setup_ns} <= '0;
         {iter, div_issued, simple_l, done, saturated} <= '0;
         {setup_cyc, hold_cyc, addr_cyc, half_period, sample_factor} <= '0;
      end else begin
         if (div_start) div_issued <= 1'b1;
         case (st)
            S_IDLE: if (start) begin
               per_l  <= period_ns;
               tds_l  <= sns_t'(tgt_setup_ns) + margin_s;
               tdh_l  <= sns_t'(tgt_hold_ns) + margin_s;
               tas_l  <= sns_t'(tgt_addr_ns) + margin_s;
               rea_l  <= sns_t'(dev_access_ns);
               rloh_l <= sns_t'(dev_low_hold_ns);
               rhoh_l <= sns_t'(dev_high_hold_ns);
               pmin_l <= sns_t'(prop_min_ns);
               pmax_l <= sns_t'(prop_max_ns);
               sreq_l <= sns_t'(sample_req_ns);
               {done, saturated, half_period} <= '0;
               {setup_cyc, hold_cyc, addr_cyc, sample_factor, iter} <= '0;
               st <= S_DS;
            end
            S_DS: if (div_vld) begin
               div_issued <= 1'b0;
               setup_cyc  <= (div_q == '0) ? DS_W'(1) : (div_q > DSMAX_N ? DSMAX_D : DS_W'(div_q));
               st <= S_DH;
            end
            S_DH: if (div_vld) begin
               div_issued <= 1'b0;
               hold_cyc   <= (div_q == '0) ? DS_W'(1) : (div_q > ALL_N ? DS_W'(ALL_N) : DS_W'(div_q));
               st <= S_AS;
            end
            S_AS: if (div_vld) begin
               div_issued <= 1'b0;
               addr_cyc   <= (div_q > ALL_N) ? DS_W'(ALL_N) : DS_W'(div_q);
               st <= S_PATH;
            end
            S_PATH: begin
               half_period <= win_half;
               setup_ns    <= per_s * ds_s;
               simple_l    <= any_unknown;
               iter        <= '0;
               ideal       <= sreq_l;
               eye         <= pmin_l + rhoh_l + per_s * ds_s - pmax_l - rea_l;
               st          <= any_unknown ? S_SIMPLE : S_EYE;
            end
            S_SIMPLE: begin
               if (!(ideal > maxd && need_more)) st <= S_FACT;
               else if (iter == CAP_I) begin
                  saturated <= 1'b1; done <= 1'b1; st <= S_IDLE;
               end else begin
                  setup_cyc <= setup_cyc + 1'b1;
                  ideal     <= (ideal_sim < 0) ? '0 : ideal_sim;
                  iter      <= iter + 1'b1;
               end
            end
            S_EYE: begin
               if (!(eye <= 0 && need_more)) st <= S_IDEAL0;
               else if (iter == CAP_I) begin
                  saturated <= 1'b1; done <= 1'b1; st <= S_IDLE;
               end else begin
                  setup_cyc <= setup_cyc + 1'b1;
                  setup_ns  <= setup_ns + per_s;
                  eye       <= eye + per_s;
                  iter      <= iter + 1'b1;
               end
            end
            S_IDEAL0: begin
               ideal <= (eye_ctr < 0) ? '0 : eye_ctr;
               iter  <= '0;
               st    <= S_CENTER;
            end
            S_CENTER: begin
               if (!(ideal > maxd && need_more)) begin
                  iter <= '0; st <= S_FACT;
               end else if (iter == CAP_I) begin
                  saturated <= 1'b1; done <= 1'b1; st <= S_IDLE;
               end else begin
                  setup_cyc <= setup_cyc + 1'b1;
                  setup_ns  <= setup_ns + per_s;
                  eye       <= eye + per_s;
                  ideal     <= (ideal_dec < 0) ? '0 : ideal_dec;
                  iter      <= iter + 1'b1;
               end
            end
            S_FACT: if (div_vld) begin
               div_issued    <= 1'b0;
               sample_factor <= (div_q > MAXF_N) ? F_W'(MAXF) : F_W'(div_q);
               if (simple_l) begin
                  done <= 1'b1; st <= S_IDLE;
               end else st <= S_REFINE;
            end
            S_REFINE: begin
               if (!ref_cond) begin
                  done <= 1'b1; st <= S_IDLE;
               end else if (iter == CAP_I) begin
                  saturated <= 1'b1; done <= 1'b1; st <= S_IDLE;
               end else begin
                  iter <= iter + 1'b1;
                  if (qdly > ideal) begin
                     if (sample_factor != '0) sample_factor <= sample_factor - 1'b1;
                  end else begin
                     setup_cyc <= setup_cyc + 1'b1;
                     setup_ns  <= setup_ns + per_s;
                     eye       <= eye + per_s;
                     ideal     <= (ideal_ref < 0) ? '0 : ideal_ref;
                     st        <= S_FACT;
                  end
               end
            end
            default: st <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/nrt_calc_chk.sv
module nrt_calc_chk #(
   parameter int DS_W   = 8,
   parameter int DS_MAX = 255,
   parameter int F_W    = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            start,
   input logic            busy,
   input logic            done,
   input logic [DS_W-1:0] setup_cyc,
   input logic [DS_W-1:0] hold_cyc,
   input logic [DS_W-1:0] addr_cyc,
   input logic            half_period,
   input logic [F_W-1:0]  sample_factor,
   input logic            saturated
);
   p_idle_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> ($stable(setup_cyc) && $stable(hold_cyc) && $stable(addr_cyc)
                             && $stable(half_period) && $stable(sample_factor)
                             && $stable(saturated) && $stable(done)));

   p_start_accept_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (busy && !done));

   p_done_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   p_setup_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (setup_cyc <= DS_W'(DS_MAX) && setup_cyc != '0));

   p_hold_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (hold_cyc != '0));

   p_sat_flag_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(saturated) |-> $rose(done));
endmodule

bind nrt_calc nrt_calc_chk #(.DS_W(DS_W), .DS_MAX(DS_MAX), .F_W(F_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
   .setup_cyc(setup_cyc), .hold_cyc(hold_cyc), .addr_cyc(addr_cyc),
   .half_period(half_period), .sample_factor(sample_factor), .saturated(saturated));

// File: tb/nrt_calc_tb_top.sv
module nrt_calc_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int DSM        = 12;
   localparam int CAP        = 8;
   localparam int WATCHDOG   = 150000;

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
   logic [7:0] period_ns, tgt_setup_ns, tgt_hold_ns, tgt_addr_ns;
   logic [3:0] chip_count;
   logic signed [7:0] dev_access_ns, dev_low_hold_ns, dev_high_hold_ns;
   logic [7:0] prop_min_ns, prop_max_ns, sample_req_ns;
   logic busy, done, half_period, saturated;
   logic [7:0] setup_cyc, hold_cyc, addr_cyc;
   logic [3:0] sample_factor;

   nrt_calc #(.DS_MAX(DSM), .LOOP_CAP(CAP)) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .period_ns(period_ns),
      .tgt_setup_ns(tgt_setup_ns), .tgt_hold_ns(tgt_hold_ns), .tgt_addr_ns(tgt_addr_ns),
      .chip_count(chip_count), .dev_access_ns(dev_access_ns),
      .dev_low_hold_ns(dev_low_hold_ns), .dev_high_hold_ns(dev_high_hold_ns),
      .prop_min_ns(prop_min_ns), .prop_max_ns(prop_max_ns), .sample_req_ns(sample_req_ns),
      .busy(busy), .done(done), .setup_cyc(setup_cyc), .hold_cyc(hold_cyc),
      .addr_cyc(addr_cyc), .half_period(half_period), .sample_factor(sample_factor),
      .saturated(saturated));

   always #(CLK_PERIOD / 2) clk = ~clk;

   typedef struct {
      string tag;
      int ds, dh, ac, half, fac, sat;
   } exp_t;

   exp_t sb_q[$];
   exp_t last_exp;
   int checks = 0, errors = 0;
   logic done_q = 1'b0;

   task automatic chk(string req, string what, int act, int expv);
      checks++;
      if (act != expv) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
      end
   endtask

   function automatic int cdiv(int a, int b);
      return (a + b - 1) / b;
   endfunction

   // reference computed from the requirements
   function automatic exp_t model(string tag, int per, int tds, int tdh, int tas, int chips,
                                  int rea, int rloh, int rhoh, int pmin, int pmax, int sreq);
      exp_t r;
      int m, sh, maxd, ideal, sns, eye, it, qd, err;
      r.tag = tag; r.sat = 0; r.fac = 0;
      m = (chips > 2) ? 10 : (chips == 2 ? 5 : 0);
      r.ds = cdiv(tds + m, per); if (r.ds < 1) r.ds = 1; if (r.ds > DSM) r.ds = DSM;
      r.dh = cdiv(tdh + m, per); if (r.dh < 1) r.dh = 1; if (r.dh > 255) r.dh = 255;
      r.ac = cdiv(tas + m, per); if (r.ac > 255) r.ac = 255;
      r.half = (per > 16) ? 1 : 0;
      sh = r.half ? 4 : 3;
      maxd = (per > 32) ? 0 : (((15 * per) >> sh) > 16 ? 16 : ((15 * per) >> sh));
      if (rea < 0 || rloh < 0 || rhoh < 0) begin
         ideal = sreq; it = 0;
         while (ideal > maxd && r.ds < DSM) begin
            if (it == CAP) begin r.sat = 1; return r; end
            r.ds++; ideal -= per; if (ideal < 0) ideal = 0; it++;
         end
         r.fac = cdiv(ideal << sh, per); if (r.fac > 15) r.fac = 15;
         return r;
      end
      sns = per * r.ds;
      eye = pmin + rhoh + sns - pmax - rea; it = 0;
      while (eye <= 0 && r.ds < DSM) begin
         if (it == CAP) begin r.sat = 1; return r; end
         r.ds++; sns += per; eye += per; it++;
      end
      ideal = (pmax + rea + pmin + rhoh - sns) >>> 1; if (ideal < 0) ideal = 0; it = 0;
      while (ideal > maxd && r.ds < DSM) begin
         if (it == CAP) begin r.sat = 1; return r; end
         r.ds++; sns += per; eye += per; ideal -= per >> 1; if (ideal < 0) ideal = 0; it++;
      end
      r.fac = cdiv(ideal << sh, per); if (r.fac > 15) r.fac = 15;
      it = 0;
      forever begin
         qd = (r.fac * per) >> sh;
         err = (qd > ideal) ? qd - ideal : ideal - qd;
         if (!(err > (eye >>> 1) && r.ds < DSM)) break;
         if (it == CAP) begin r.sat = 1; return r; end
         if (qd > ideal) begin
            if (r.fac != 0) r.fac--;
         end else begin
            r.ds++; sns += per; eye += per; ideal -= (per >> 1) + per;
            if (ideal < 0) ideal = 0;
            r.fac = cdiv(ideal << sh, per); if (r.fac > 15) r.fac = 15;
         end
         it++;
      end
      return r;
   endfunction

   // monitor: compare each finished result with the oldest expectation
   initial begin
      forever begin
         @(negedge clk);
         if (done && !done_q) begin
            if (sb_q.size() == 0) begin
               checks++; errors++;
               $display("FAIL R13 unexpected done actual=1 expected=0");
            end else begin
               exp_t e;
               e = sb_q.pop_front();
               chk(e.tag, "setup_cyc", int'(setup_cyc), e.ds);
               chk("R3", {e.tag, " hold_cyc"}, int'(hold_cyc), e.dh);
               chk("R3", {e.tag, " addr_cyc"}, int'(addr_cyc), e.ac);
               chk("R4", {e.tag, " half_period"}, int'(half_period), e.half);
               chk("R9", {e.tag, " sample_factor"}, int'(sample_factor), e.fac);
               chk("R12", {e.tag, " saturated"}, int'(saturated), e.sat);
               last_exp = e;
            end
         end
         done_q = done;
      end
   end

   task automatic drive(int per, int tds, int tdh, int tas, int chips, int rea, int rloh,
                        int rhoh, int pmin, int pmax, int sreq);
      period_ns = 8'(per); tgt_setup_ns = 8'(tds); tgt_hold_ns = 8'(tdh);
      tgt_addr_ns = 8'(tas); chip_count = 4'(chips);
      dev_access_ns = 8'(rea); dev_low_hold_ns = 8'(rloh); dev_high_hold_ns = 8'(rhoh);
      prop_min_ns = 8'(pmin); prop_max_ns = 8'(pmax); sample_req_ns = 8'(sreq);
   endtask

   task automatic pulse_start();
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
   endtask

   task automatic wait_empty();
      for (int i = 0; i < 5000 && sb_q.size() != 0; i++) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic run(string tag, int per, int tds, int tdh, int tas, int chips, int rea,
                      int rloh, int rhoh, int pmin, int pmax, int sreq);
      drive(per, tds, tdh, tas, chips, rea, rloh, rhoh, pmin, pmax, sreq);
      sb_q.push_back(model(tag, per, tds, tdh, tas, chips, rea, rloh, rhoh, pmin, pmax, sreq));
      pulse_start();
      wait_empty();
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      checks++; errors++;
      $display("FAIL R13 watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      drive(10, 0, 0, 0, 1, -1, -1, -1, 0, 0, 0);
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1", "busy", int'(busy), 0);
      chk("R1", "done", int'(done), 0);
      chk("R1", "setup_cyc", int'(setup_cyc), 0);
      chk("R1", "hold/addr", int'(hold_cyc) + int'(addr_cyc), 0);
      chk("R1", "factor/half/sat", int'(sample_factor) + int'(half_period) + int'(saturated), 0);

      run("R6 simple trade", 10, 15, 8, 0, 1, -1, 5, 5, 0, 0, 40);
      run("R2 one chip", 10, 6, 16, 1, 1, -1, 0, 0, 0, 0, 0);
      run("R2 two chips", 10, 6, 16, 1, 2, -1, 0, 0, 0, 0, 0);
      run("R2 three chips", 10, 6, 16, 1, 3, -1, 0, 0, 0, 0, 0);
      run("R7 eye opening", 8, 5, 8, 3, 1, 30, 2, 5, 1, 10, 0);
      run("R8 centring", 10, 10, 10, 10, 1, 40, 3, 20, 5, 10, 0);
      run("R10 refine", 30, 10, 25, 31, 1, 30, 1, 3, 2, 4, 0);
      run("R4 period 16", 16, 16, 4, 0, 1, -1, 0, 0, 0, 0, 20);
      run("R4 period 17", 17, 16, 4, 0, 1, -1, 0, 0, 0, 0, 20);
      run("R5 period 32", 32, 10, 4, 0, 1, -1, 0, 0, 0, 0, 60);
      run("R5 period 33", 33, 10, 4, 0, 1, -1, 0, 0, 0, 0, 60);
      run("R5 slow clock", 40, 10, 4, 0, 1, -1, 0, 0, 0, 0, 50);
      run("R11 setup limit", 20, 200, 4, 0, 1, -1, 0, 0, 0, 0, 250);
      run("R9 factor cap", 20, 20, 4, 0, 1, 0, -3, 0, 0, 0, 250);
      run("R12 loop cap", 5, 0, 4, 0, 1, -1, 0, 0, 0, 0, 100);

      // R13: start while busy is ignored
      drive(10, 15, 8, 0, 1, -1, 5, 5, 0, 0, 40);
      sb_q.push_back(model("R13 busy start", 10, 15, 8, 0, 1, -1, 5, 5, 0, 0, 40));
      pulse_start();
      repeat (3) @(negedge clk);
      drive(20, 100, 100, 100, 4, 10, 10, 10, 0, 0, 0);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
      wait_empty();

      // R13: idle outputs ignore input changes without start
      drive(7, 90, 90, 90, 3, 5, 5, 5, 9, 9, 9);
      repeat (20) @(negedge clk);
      chk("R13", "idle done", int'(done), 1);
      chk("R13", "idle setup_cyc", int'(setup_cyc), last_exp.ds);
      chk("R13", "idle hold_cyc", int'(hold_cyc), last_exp.dh);
      chk("R13", "idle sample_factor", int'(sample_factor), last_exp.fac);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule